// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block with Term Steering

This block is a configurable AND-OR logic slice. A set of input signals is turned into true and complement literals. A static configuration picks, for every product term, which literals take part in it. A steering network then collects the product terms into a row of output sums. Each output row owns a fixed group of terms. Any term can stay in its own row, be lent toward a row of lower or higher index, or be switched off. A lent term travels along a chain of rows. Each row chooses whether to absorb the traffic arriving from each side or to let it pass on. This lets a single output gather every term in the block.

The sums are registered. When local feedback is built in, the registered outputs come back as extra literal sources. State machines and counters can then be formed without leaving the block. All configuration ports are meant to be held static while the block runs. Reset is synchronous and active high, and clears the outputs.

Top module: `sop_fblock`

## Requirements
- R1: Source j yields literal 2j (its true value) and literal 2j+1 (its complement). Sources 0..N_IN-1 are `in_sig` bits. Term t's enable row is `lit_en[t*N_LIT +: N_LIT]`.
- R2: A product term is the AND of its enabled literals. A term with no literal enabled evaluates to 1.
- R3: A term that enables both the true and complement literal of the same source evaluates to 0 for any input value.
- R4: Term t belongs to slot t/TERMS_PER_SLOT. The route code is `route_cfg[2t+1:2t]`, and code 0 (keep) adds the term to its own slot's sum.
- R5: Code 1 sends the term toward lower slot indices. Code 2 sends it toward higher slot indices. The traffic is absorbed by the first slot on the way whose pass flag for that direction (`pass_lo` for traffic moving to lower indices, `pass_hi` for traffic moving to higher indices) is 0. Slots whose flag is 1 forward the traffic.
- R6: A term that is lent away (code 1 or 2) does not appear in its own slot's sum. A slot that passes traffic on does not take it into its own sum.
- R7: Code 3 disconnects a term. A slot that receives no term outputs 0.
- R8: Every one of the N_OUT*TERMS_PER_SLOT terms can be steered into one single output.
- R9: Outputs are registered and show the sums one clock after the inputs. A synchronous reset clears all outputs to 0 at the next edge.
- R10: With LOCAL_FB=1, sources N_IN..N_IN+N_OUT-1 are the registered outputs `sum_q[0..N_OUT-1]`.
- R11: Traffic that leaves slot 0 toward lower indices, or leaves the last slot toward higher indices, is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sig | input | N_IN | Logic input signals |
| lit_en | input | N_TERM*N_LIT | Literal enables, one row of N_LIT bits per term |
| route_cfg | input | 2*N_TERM | Per-term route code: 0 keep, 1 lower, 2 higher, 3 off |
| pass_lo | input | N_OUT | Per slot: forward traffic moving to lower indices instead of absorbing it |
| pass_hi | input | N_OUT | Per slot: forward traffic moving to higher indices instead of absorbing it |
| sum_q | output | N_OUT | Registered output sums |

## Verification
The assertions assume that the configuration ports hold still for the clock after they are sampled. They also assume that `in_sig` and the configuration carry known values whenever reset is low. The bench therefore changes configuration and inputs only at the falling edge, while reset is high or a full clock before the output is sampled. It drives every configuration bit from the first instant, so no X reaches the literals. Feedback checks start from a reset, so the registered sources begin at a known 0.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    RT_KEEP = 2'd0,
    RT_LO   = 2'd1,
    RT_HI   = 2'd2,
    RT_OFF  = 2'd3
  } route_e;
endpackage

// File: rtl/sop_literals.sv
module sop_literals #(
  parameter int N_SRC = 54
) (
  input  logic [N_SRC-1:0]   src,
  output logic [2*N_SRC-1:0] lit
);
  for (genvar j = 0; j < N_SRC; j++) begin : g_lit
    assign lit[2*j]   = src[j];
    assign lit[2*j+1] = ~src[j];
  end
endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
  parameter int N_LIT  = 108,
  parameter int N_TERM = 90
) (
  input  logic [N_LIT-1:0]        lit,
  input  logic [N_TERM*N_LIT-1:0] lit_en,
  output logic [N_TERM-1:0]       term
);
  // a disabled literal is forced to 1 so it drops out of the AND
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term[t] = &(lit | ~lit_en[t*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/sop_allocator.sv
module sop_allocator
  import sop_pkg::*;
#(
  parameter int N_OUT = 18,
  parameter int TPS   = 5,
  localparam int N_TERM = N_OUT * TPS
) (
  input  logic [N_TERM-1:0]   term,
  input  logic [2*N_TERM-1:0] route_cfg,
  input  logic [N_OUT-1:0]    pass_lo,
  input  logic [N_OUT-1:0]    pass_hi,
  output logic [N_OUT-1:0]    slot_sum
);
  logic [N_OUT-1:0] keep_own, lo_own, hi_own;
  logic [N_OUT-1:0] lo_in, hi_in;

  // per-slot OR of own terms, split by route code
  always_comb begin
    keep_own = '0;
    lo_own   = '0;
    hi_own   = '0;
    for (int s = 0; s < N_OUT; s++) begin
      for (int k = 0; k < TPS; k++) begin
        case (route_e'(route_cfg[2*(s*TPS+k) +: 2]))
          RT_KEEP: keep_own[s] = keep_own[s] | term[s*TPS+k];
          RT_LO:   lo_own[s]   = lo_own[s]   | term[s*TPS+k];
          RT_HI:   hi_own[s]   = hi_own[s]   | term[s*TPS+k];
          default: ;
        endcase
      end
    end
  end

  // chain toward lower indices: enters at the top slot, exits past slot 0
  always_comb begin
    logic carry;
    carry = 1'b0;
    for (int s = N_OUT - 1; s >= 0; s--) begin
      lo_in[s] = carry;
      carry    = lo_own[s] | (pass_lo[s] & carry);
    end
  end

  // chain toward higher indices: enters at slot 0, exits past the top slot
  always_comb begin
    logic carry;
    carry = 1'b0;
    for (int s = 0; s < N_OUT; s++) begin
      hi_in[s] = carry;
      carry    = hi_own[s] | (pass_hi[s] & carry);
    end
  end

  assign slot_sum = keep_own | (~pass_lo & lo_in) | (~pass_hi & hi_in);
endmodule

// File: rtl/sop_fblock.sv
module sop_fblock
  import sop_pkg::*;
#(
  parameter int N_IN     = 36,
  parameter int N_OUT    = 18,
  parameter int TPS      = 5,
  parameter bit LOCAL_FB = 1'b1,
  localparam int N_TERM = N_OUT * TPS,
  localparam int N_FB   = LOCAL_FB ? N_OUT : 0,
  localparam int N_SRC  = N_IN + N_FB,
  localparam int N_LIT  = 2 * N_SRC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IN-1:0]         in_sig,
  input  logic [N_TERM*N_LIT-1:0] lit_en,
  input  logic [2*N_TERM-1:0]     route_cfg,
  input  logic [N_OUT-1:0]        pass_lo,
  input  logic [N_OUT-1:0]        pass_hi,
  output logic [N_OUT-1:0]        sum_q
);
  logic [N_SRC-1:0]  src;
  logic [N_LIT-1:0]  lit;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  slot_sum;

  if (LOCAL_FB) begin : g_fb
    assign src = {sum_q, in_sig};
  end else begin : g_nofb
    assign src = in_sig;
  end

  sop_literals #(.N_SRC(N_SRC)) u_lit (
    .src (src),
    .lit (lit)
  );

  sop_and_array #(.N_LIT(N_LIT), .N_TERM(N_TERM)) u_and (
    .lit    (lit),
    .lit_en (lit_en),
    .term   (term)
  );

  sop_allocator #(.N_OUT(N_OUT), .TPS(TPS)) u_alloc (
    .term      (term),
    .route_cfg (route_cfg),
    .pass_lo   (pass_lo),
    .pass_hi   (pass_hi),
    .slot_sum  (slot_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= slot_sum;
  end

  // ---------------- assertions ----------------
  function automatic logic has_pair(input logic [N_LIT-1:0] row);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < N_SRC; j++) hit = hit | (row[2*j] & row[2*j+1]);
    return hit;
  endfunction

  function automatic logic slot_all_lent(input logic [2*N_TERM-1:0] rc, input int s);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < TPS; k++) begin
      ok = ok & ((rc[2*(s*TPS+k) +: 2] == RT_LO) || (rc[2*(s*TPS+k) +: 2] == RT_HI));
    end
    return ok;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sum_q == '0)); // R9

  AST_ALL_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (&route_cfg) |=> (sum_q == '0)); // R7

  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    AST_EMPTY_TERM_ONE: assert property (@(posedge clk) disable iff (rst)
      (lit_en[t*N_LIT +: N_LIT] == '0) |-> term[t]); // R2
    AST_PAIR_TERM_ZERO: assert property (@(posedge clk) disable iff (rst)
      has_pair(lit_en[t*N_LIT +: N_LIT]) |-> !term[t]); // R3
  end

  for (genvar s = 0; s < N_OUT; s++) begin : g_slot_chk
    AST_LENT_TERMS_LEAVE: assert property (@(posedge clk) disable iff (rst)
      (slot_all_lent(route_cfg, s) && pass_lo[s] && pass_hi[s]) |-> !slot_sum[s]); // R6
  end
endmodule

// File: tb/sim_sop_fblock.sv
module sim_sop_fblock;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN   = 36;
  localparam int N_OUT  = 18;
  localparam int TPS    = 5;
  localparam int N_TERM = N_OUT * TPS;
  localparam int N_SRC  = N_IN + N_OUT;
  localparam int N_LIT  = 2 * N_SRC;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [N_IN-1:0]         in_sig = '0;
  logic [N_TERM*N_LIT-1:0] lit_en = '0;
  logic [2*N_TERM-1:0]     route_cfg = '1;
  logic [N_OUT-1:0]        pass_lo = '0;
  logic [N_OUT-1:0]        pass_hi = '0;
  logic [N_OUT-1:0]        sum_q;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_fblock #(.N_IN(N_IN), .N_OUT(N_OUT), .TPS(TPS), .LOCAL_FB(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_sig(in_sig), .lit_en(lit_en),
    .route_cfg(route_cfg), .pass_lo(pass_lo), .pass_hi(pass_hi), .sum_q(sum_q)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N_OUT-1:0] exp);
    checks++;
    if (sum_q !== exp) begin
      fails++;
      $display("FAIL %s: sum_q=%h expected=%h", req, sum_q, exp);
    end
  endtask

  task automatic clear_cfg();
    lit_en    = '0;
    route_cfg = '1;
    pass_lo   = '0;
    pass_hi   = '0;
    in_sig    = '0;
  endtask

  task automatic set_lit(input int t, input int src, input bit comp);
    lit_en[t*N_LIT + 2*src + (comp ? 1 : 0)] = 1'b1;
  endtask

  task automatic set_route(input int t, input logic [1:0] code);
    route_cfg[2*t +: 2] = code;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_sig = '1;
    lit_en = '0;
    route_cfg = '0;
    step();
    chk("R9 reset clears outputs", '0);
    rst = 1'b0;
    step();
    chk("R9 all-empty kept terms give ones one cycle later", '1);
    clear_cfg();
    step();
  endtask

  task automatic t_empty_term();
    clear_cfg();
    set_route(0, 2'd0);
    step();
    chk("R2 R4 empty kept term drives slot 0; R7 other slots zero", 18'h1);
    clear_cfg();
    step();
    chk("R7 all terms off gives zero", '0);
  endtask

  task automatic t_literals();
    clear_cfg();
    set_route(5, 2'd0);
    set_lit(5, 3, 1'b0);
    set_lit(5, 7, 1'b1);
    in_sig[3] = 1'b1; in_sig[7] = 1'b0;
    step();
    chk("R1 R2 in3 & ~in7 true", 18'h2);
    in_sig[7] = 1'b1;
    step();
    chk("R1 R2 complement literal blocks", 18'h0);
    in_sig[3] = 1'b0; in_sig[7] = 1'b0;
    step();
    chk("R1 R2 true literal blocks", 18'h0);
  endtask

  task automatic t_conflict();
    clear_cfg();
    set_route(10, 2'd0);
    set_lit(10, 4, 1'b0);
    set_lit(10, 4, 1'b1);
    in_sig[4] = 1'b0;
    step();
    chk("R3 true+complement with input 0", '0);
    in_sig[4] = 1'b1;
    step();
    chk("R3 true+complement with input 1", '0);
  endtask

  task automatic t_steer();
    clear_cfg();
    set_route(20, 2'd1);
    step();
    chk("R5 R6 lent down-index absorbed by slot 3", 18'h8);
    pass_lo[3] = 1'b1;
    step();
    chk("R5 R6 passed by slot 3, absorbed by slot 2", 18'h4);
    clear_cfg();
    set_route(20, 2'd2);
    step();
    chk("R5 R6 lent up-index absorbed by slot 5", 18'h20);
    pass_hi[5] = 1'b1;
    pass_hi[6] = 1'b1;
    step();
    chk("R5 passed by slots 5,6, absorbed by slot 7", 18'h80);
  endtask

  task automatic t_edges();
    clear_cfg();
    set_route(0, 2'd1);
    step();
    chk("R11 slot 0 sending lower is dropped", '0);
    clear_cfg();
    set_route(N_TERM-1, 2'd2);
    step();
    chk("R11 top slot sending higher is dropped", '0);
    clear_cfg();
    set_route(30, 2'd1);
    for (int s = 0; s < 6; s++) pass_lo[s] = 1'b1;
    step();
    chk("R11 passed past slot 0 is dropped", '0);
  endtask

  task automatic t_gather_all();
    clear_cfg();
    for (int t = 0; t < N_TERM; t++) begin
      if (t / TPS < 9)      set_route(t, 2'd2);
      else if (t / TPS > 9) set_route(t, 2'd1);
      else                  set_route(t, 2'd0);
    end
    for (int s = 0; s < 9; s++)      pass_hi[s] = 1'b1;
    for (int s = 10; s < N_OUT; s++) pass_lo[s] = 1'b1;
    for (int k = 0; k < N_TERM; k++) begin
      for (int t = 0; t < N_TERM; t++) begin
        lit_en[t*N_LIT +: N_LIT] = '0;
        if (t != k) begin
          set_lit(t, 0, 1'b0);
          set_lit(t, 0, 1'b1);
        end
      end
      step();
      chk($sformatf("R8 term %0d reaches slot 9", k), 18'h200);
    end
  endtask

  task automatic t_feedback();
    clear_cfg();
    rst = 1'b1;
    set_route(15, 2'd0);
    set_lit(15, N_IN + 3, 1'b0);
    set_route(16, 2'd0);
    set_lit(16, 0, 1'b0);
    set_route(20, 2'd0);
    set_lit(20, N_IN + 4, 1'b1);
    step();
    chk("R9 reset before feedback", '0);
    rst = 1'b0;
    in_sig[0] = 1'b1;
    step();
    chk("R10 set latch, toggle rises", 18'h18);
    in_sig[0] = 1'b0;
    step();
    chk("R10 latch holds via feedback, toggle falls", 18'h08);
    step();
    chk("R10 latch holds, toggle rises", 18'h18);
    rst = 1'b1;
    step();
    chk("R9 reset clears latched feedback", '0);
    rst = 1'b0;
    step();
    chk("R10 after reset latch stays clear, toggle rises", 18'h10);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_empty_term();
    t_literals();
    t_conflict();
    t_steer();
    t_edges();
    t_gather_all();
    t_feedback();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule